// File: doc/BRIEF.md
# Read Return Latency Tracker for a 32-bit Synchronous DRAM Controller

This block sits on the controller side of a single-data-rate synchronous DRAM with a 32-bit data word split into four 8-bit lanes. The controller gives it read, write, burst-stop and bank-close command pulses together with a burst-length code. The block expands each command into per-cycle beats. For every read beat it raises a capture strobe exactly when the returned word is due, and with it a per-lane enable that follows the lane-mask lines with a fixed two-clock lag. Write beats are reported in the same cycle as the command, and their lane enables follow the mask lines with no lag.

Read beats travel through a short shift register whose tap is chosen by the programmed return latency of 2 or 3 clocks. A newer read or write command replaces a running burst, and a stop or close command ends it. In both cases, beats that were already issued still come back, and beats that were not yet issued never appear. A new latency setting is taken only when nothing is in flight, so a burst never straddles two latencies.

Top module: `sdr_read_lat`

## Requirements
- R1: While reset is held, and until the first read beat arrives, `rd_valid`, `rd_lane_en`, `wr_strobe` and `wr_lane_en` are all zero.
- R2: A read beat issued at clock edge n gives `rd_valid` = 1 for capture at edge n+L, which means it is visible for one cycle after edge n+L-1. L is 3 when the active setting is 3 and 2 for any other `cfg_lat` value.
- R3: `burst_code` values 0, 1, 2 and 3 give 1, 2, 4 and 8 beats on consecutive edges, starting at the command edge.
- R4: For a valid read beat, `rd_lane_en[i]` (data bits 8i+7:8i) equals the inverse of `lane_mask[i]` as sampled two edges before the capture edge.
- R5: During a write beat, `wr_strobe` = 1 and `wr_lane_en` equals the inverse of `lane_mask` in that same cycle. Outside write beats, both are zero.
- R6: A read or write command on any edge replaces the running burst. Beats of the old burst not yet issued are dropped, and the new burst has its full length.
- R7: `cmd_stop` ends the running read or write burst. No beat is issued at the stop edge or after it, unless a new command arrives.
- R8: `cmd_close` ends a running burst the same way. As a result, read data stops L edges after the close edge.
- R9: A new `cfg_lat` value takes effect only on an edge where no read beat is in flight, no burst is running and no read beat is issued.
- R10: When commands coincide on one edge, a read wins over a write, and either command wins over stop or close.
- R11: When `rd_valid` is 0, `rd_lane_en` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_rd | input | 1 | Read command pulse |
| cmd_wr | input | 1 | Write command pulse |
| cmd_stop | input | 1 | Burst-stop command pulse |
| cmd_close | input | 1 | Bank-close (precharge) command pulse |
| burst_code | input | 2 | Burst length code: 1 << code beats |
| lane_mask | input | 4 | Per-lane mask, one bit per 8-bit lane |
| cfg_lat | input | 2 | Requested read return latency (3, else 2) |
| rd_valid | output | 1 | Read data capture strobe |
| rd_lane_en | output | 4 | Per-lane enable for the captured read word |
| wr_strobe | output | 1 | Write beat in this cycle |
| wr_lane_en | output | 4 | Per-lane enable for the write word of this cycle |

## Verification
Each output has its own due time after the stimulus that causes it. A read strobe is due L edges after the issuing edge, a read lane enable reflects the mask sampled two edges before capture, and write strobes and enables are due in the very cycle of the command. The driver computes the capture cycle of every read beat when it issues the command, including the shortened counts after a replacement, stop or close, and queues it with its requirement tag. The monitor samples one time unit after each falling edge, pops the queue front when the strobe appears, and rebuilds the expected lane enable from a record of the masks the driver applied. Write outputs are checked directly after driving, because they have no latency.

// File: rtl/sdr_read_lat_pkg.sv
package sdr_read_lat_pkg;

  typedef enum logic [1:0] {
    BK_IDLE  = 2'd0,
    BK_READ  = 2'd1,
    BK_WRITE = 2'd2
  } burst_kind_e;

  // number of beats selected by a burst code
  function automatic int unsigned beats_of(input int unsigned code);
    return 32'd1 << code;
  endfunction

  // requested latency: the top value is honoured, anything else maps to the low value
  function automatic int unsigned lat_pick(input int unsigned req,
                                           input int unsigned lo,
                                           input int unsigned hi);
    return (req >= hi) ? hi : lo;
  endfunction

endpackage

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
  import sdr_read_lat_pkg::*;
#(
  parameter int CODE_W = 2,
  localparam int MAX_BURST = 1 << ((1 << CODE_W) - 1),
  localparam int CNT_W = $clog2(MAX_BURST) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_stop,
  input  logic              cmd_close,
  input  logic [CODE_W-1:0] burst_code,
  output logic              rd_beat,
  output logic              wr_beat,
  output logic              busy
);

  burst_kind_e      kind_q;
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] len;
  logic             kill;
  logic             start_rd;
  logic             start_wr;
  logic             cont;

  assign len      = CNT_W'(beats_of(int'(burst_code)));
  assign kill     = cmd_stop | cmd_close;
  assign start_rd = cmd_rd;
  assign start_wr = cmd_wr & ~cmd_rd;
  assign cont     = ~cmd_rd & ~cmd_wr & ~kill & (kind_q != BK_IDLE);

  assign rd_beat = start_rd | (cont & (kind_q == BK_READ));
  assign wr_beat = start_wr | (cont & (kind_q == BK_WRITE));
  assign busy    = (kind_q != BK_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= BK_IDLE;
      rem_q  <= '0;
    end else if (start_rd || start_wr) begin
      rem_q <= len - CNT_W'(1);
      if (len > CNT_W'(1)) kind_q <= start_rd ? BK_READ : BK_WRITE;
      else                 kind_q <= BK_IDLE;
    end else if (cont) begin
      rem_q <= rem_q - CNT_W'(1);
      if (rem_q == CNT_W'(1)) kind_q <= BK_IDLE;
    end else if (kill) begin
      kind_q <= BK_IDLE;
      rem_q  <= '0;
    end
  end

  // R3: a running burst always has beats left
  a_r3_rem_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q != BK_IDLE) |-> (rem_q != '0));

  // R10: never a read and a write beat together
  a_r10_one_beat_kind: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_beat, wr_beat}));

  // R7: after a lone stop/close, only fresh commands produce beats
  a_r7_stop_ends_burst: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !cmd_rd && !cmd_wr) |=> (rd_beat == cmd_rd && wr_beat == cmd_wr));

  // R8: a lone close issues no beat in its own cycle
  a_r8_close_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_close && !cmd_rd && !cmd_wr) |-> (!rd_beat && !wr_beat));

endmodule

// File: rtl/sdr_lat_pipe.sv
module sdr_lat_pipe
  import sdr_read_lat_pkg::*;
#(
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  localparam int LW = $clog2(MAX_CL + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_in,
  input  logic          busy,
  input  logic [LW-1:0] cfg_lat,
  output logic          valid_out
);

  logic [MAX_CL:1] stage_q;
  logic [MAX_CL:0] tap;
  logic [LW-1:0]   lat_q;
  logic            empty;

  assign tap       = {stage_q, beat_in};
  assign empty     = (stage_q == '0) & ~busy & ~beat_in;
  assign valid_out = tap[lat_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      lat_q   <= LW'(MAX_CL);
    end else begin
      stage_q <= tap[MAX_CL-1:0];
      if (empty) lat_q <= LW'(lat_pick(int'(cfg_lat), MIN_CL, MAX_CL));
    end
  end

  // R9: the latency only moves on an empty cycle
  a_r9_lat_change_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lat_q) |-> $past(empty));

  // R2: beat emerges after exactly the active latency
  a_r2_high_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_in && lat_q == LW'(MAX_CL)) |-> ##MAX_CL valid_out);

  a_r2_low_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_in && lat_q == LW'(MIN_CL)) |-> ##MIN_CL valid_out);

endmodule

// File: rtl/sdr_mask_delay.sv
module sdr_mask_delay #(
  parameter int LANES    = 4,
  parameter int MASK_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] mask_in,
  output logic [LANES-1:0] mask_out
);

  logic [LANES-1:0] chain [MASK_LAT];

  for (genvar g = 0; g < MASK_LAT; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= mask_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= '0;
        else        chain[g] <= chain[g-1];
      end
    end
  end

  assign mask_out = chain[MASK_LAT-1];

endmodule

// File: rtl/sdr_read_lat.sv
module sdr_read_lat #(
  parameter int CODE_W   = 2,
  parameter int LANES    = 4,
  parameter int MIN_CL   = 2,
  parameter int MAX_CL   = 3,
  parameter int MASK_LAT = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_rd,
  input  logic                          cmd_wr,
  input  logic                          cmd_stop,
  input  logic                          cmd_close,
  input  logic [CODE_W-1:0]             burst_code,
  input  logic [LANES-1:0]              lane_mask,
  input  logic [$clog2(MAX_CL+1)-1:0]   cfg_lat,
  output logic                          rd_valid,
  output logic [LANES-1:0]              rd_lane_en,
  output logic                          wr_strobe,
  output logic [LANES-1:0]              wr_lane_en
);

  logic             rd_beat;
  logic             wr_beat;
  logic             busy;
  logic [LANES-1:0] mask_late;

  sdr_burst_seq #(.CODE_W(CODE_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_rd     (cmd_rd),
    .cmd_wr     (cmd_wr),
    .cmd_stop   (cmd_stop),
    .cmd_close  (cmd_close),
    .burst_code (burst_code),
    .rd_beat    (rd_beat),
    .wr_beat    (wr_beat),
    .busy       (busy)
  );

  sdr_lat_pipe #(.MIN_CL(MIN_CL), .MAX_CL(MAX_CL)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .beat_in   (rd_beat),
    .busy      (busy),
    .cfg_lat   (cfg_lat),
    .valid_out (rd_valid)
  );

  sdr_mask_delay #(.LANES(LANES), .MASK_LAT(MASK_LAT)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .mask_in  (lane_mask),
    .mask_out (mask_late)
  );

  assign rd_lane_en = rd_valid ? ~mask_late : '0;
  assign wr_strobe  = wr_beat;
  assign wr_lane_en = wr_beat ? ~lane_mask : '0;

  // R4: read lane enables follow the mask with its fixed lag
  a_r4_read_mask_lag: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_lane_en == ~$past(lane_mask, MASK_LAT)));

endmodule

// File: tb/sdr_read_lat_tb.sv
module sdr_read_lat_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_rd = 0, cmd_wr = 0, cmd_stop = 0, cmd_close = 0;
  logic [1:0] burst_code = '0;
  logic [3:0] lane_mask = '0;
  logic [1:0] cfg_lat = 2'd3;
  logic       rd_valid;
  logic [3:0] rd_lane_en;
  logic       wr_strobe;
  logic [3:0] wr_lane_en;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge = 0;
  logic [3:0] lane_hist [0:4095];
  int    exp_cyc[$];
  string exp_req[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdr_read_lat u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .cmd_stop(cmd_stop), .cmd_close(cmd_close), .burst_code(burst_code),
    .lane_mask(lane_mask), .cfg_lat(cfg_lat), .rd_valid(rd_valid),
    .rd_lane_en(rd_lane_en), .wr_strobe(wr_strobe), .wr_lane_en(wr_lane_en)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drive one edge's worth of inputs; the next rising edge samples them
  task automatic tick(input logic rd, input logic wr, input logic stp,
                      input logic cls, input logic [1:0] bc, input logic [3:0] msk);
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_stop = stp; cmd_close = cls;
    burst_code = bc; lane_mask = msk;
    lane_hist[cyc+1] = msk;
    last_edge = cyc + 1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 2'd0, 4'd0);
  endtask

  // beat k issued at edge e+k is captured at edge e+k+lat, seen by the monitor at cyc e+k+lat-1
  task automatic expect_beats(input int e, input int n, input int lat, input string req);
    for (int k = 0; k < n; k++) begin
      exp_cyc.push_back(e + lat - 1 + k);
      exp_req.push_back(req);
    end
  endtask

  // monitor: scoreboard pop and compare
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n) begin
        chk(rd_valid || rd_lane_en == 4'd0, "R11", "lanes while idle", int'(rd_lane_en), 0);
        if (rd_valid) begin
          if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
            logic [3:0] e_l;
            e_l = ~lane_hist[cyc-1];
            chk(rd_lane_en == e_l, exp_req[0], "read lane enables", int'(rd_lane_en), int'(e_l));
            void'(exp_cyc.pop_front());
            void'(exp_req.pop_front());
          end else begin
            chk(1'b0, (exp_req.size() > 0) ? exp_req[0] : "R2", "unexpected read beat at cycle",
                cyc, (exp_cyc.size() > 0) ? exp_cyc[0] : -1);
          end
        end else if (exp_cyc.size() > 0 && exp_cyc[0] <= cyc) begin
          chk(1'b0, exp_req[0], "missing read beat at cycle", cyc, exp_cyc[0]);
          void'(exp_cyc.pop_front());
          void'(exp_req.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) lane_hist[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(rd_valid == 0, "R1", "rd_valid in reset", int'(rd_valid), 0);
    chk(rd_lane_en == 0, "R1", "rd_lane_en in reset", int'(rd_lane_en), 0);
    chk(wr_strobe == 0, "R1", "wr_strobe in reset", int'(wr_strobe), 0);
    chk(wr_lane_en == 0, "R1", "wr_lane_en in reset", int'(wr_lane_en), 0);
    rst_n = 1'b1;
    idle(3);
    chk(rd_valid == 0 && wr_strobe == 0, "R1", "outputs after reset", int'(rd_valid), 0);

    // R2: latency 3, four beats
    tick(1, 0, 0, 0, 2'd2, 4'd0); expect_beats(last_edge, 4, 3, "R2");
    idle(8);

    // R3: remaining burst codes
    for (int c = 0; c < 4; c++) begin
      if (c != 2) begin
        tick(1, 0, 0, 0, 2'(c), 4'd0); expect_beats(last_edge, 1 << c, 3, "R3");
        idle(12);
      end
    end

    // R8: close during a latency-3 read ends data three edges later
    tick(1, 0, 0, 0, 2'd3, 4'd0); expect_beats(last_edge, 2, 3, "R8");
    idle(1);
    tick(0, 0, 0, 1, 2'd0, 4'd0);
    idle(8);

    // R9: latency request during a burst is deferred until drained
    tick(1, 0, 0, 0, 2'd3, 4'd0); expect_beats(last_edge, 8, 3, "R9");
    idle(1);
    cfg_lat = 2'd2;
    idle(14);
    tick(1, 0, 0, 0, 2'd0, 4'd0); expect_beats(last_edge, 1, 2, "R9");
    idle(6);

    // R2: latency 2, four beats
    tick(1, 0, 0, 0, 2'd2, 4'd0); expect_beats(last_edge, 4, 2, "R2");
    idle(6);

    // R4: lane masks changing during an eight-beat read
    tick(1, 0, 0, 0, 2'd3, 4'b0000); expect_beats(last_edge, 8, 2, "R4");
    tick(0, 0, 0, 0, 2'd0, 4'b0001);
    tick(0, 0, 0, 0, 2'd0, 4'b0001);
    tick(0, 0, 0, 0, 2'd0, 4'b1010);
    tick(0, 0, 0, 0, 2'd0, 4'b1111);
    tick(0, 0, 0, 0, 2'd0, 4'b0110);
    tick(0, 0, 0, 0, 2'd0, 4'b1000);
    tick(0, 0, 0, 0, 2'd0, 4'b0100);
    tick(0, 0, 0, 0, 2'd0, 4'b0010);
    idle(6);

    // R6: read replaced by read
    tick(1, 0, 0, 0, 2'd3, 4'd0); expect_beats(last_edge, 3, 2, "R6");
    idle(2);
    tick(1, 0, 0, 0, 2'd1, 4'd0); expect_beats(last_edge, 2, 2, "R6");
    idle(6);

    // R6: read replaced by write
    tick(1, 0, 0, 0, 2'd2, 4'd0); expect_beats(last_edge, 1, 2, "R6");
    tick(0, 1, 0, 0, 2'd0, 4'd0);
    #1 chk(wr_strobe == 1, "R6", "write strobe on replacing write", int'(wr_strobe), 1);
    idle(1);
    #1 chk(wr_strobe == 0, "R6", "single write beat ended", int'(wr_strobe), 0);
    idle(6);

    // R7: stop during a read
    tick(1, 0, 0, 0, 2'd3, 4'd0); expect_beats(last_edge, 3, 2, "R7");
    idle(2);
    tick(0, 0, 1, 0, 2'd0, 4'd0);
    idle(6);

    // R7: stop during a write
    tick(0, 1, 0, 0, 2'd2, 4'd0);
    #1 chk(wr_strobe == 1, "R7", "write beat 0", int'(wr_strobe), 1);
    idle(1);
    #1 chk(wr_strobe == 1, "R7", "write beat 1", int'(wr_strobe), 1);
    tick(0, 0, 1, 0, 2'd0, 4'd0);
    #1 chk(wr_strobe == 0, "R7", "write at stop edge", int'(wr_strobe), 0);
    idle(1);
    #1 chk(wr_strobe == 0, "R7", "write after stop", int'(wr_strobe), 0);
    idle(4);

    // R8: close under latency 2
    tick(1, 0, 0, 0, 2'd3, 4'd0); expect_beats(last_edge, 1, 2, "R8");
    tick(0, 0, 0, 1, 2'd0, 4'd0);
    idle(6);

    // R10: coinciding commands
    tick(1, 1, 0, 0, 2'd0, 4'd0); expect_beats(last_edge, 1, 2, "R10");
    #1 chk(wr_strobe == 0, "R10", "write loses to read", int'(wr_strobe), 0);
    idle(4);
    tick(1, 0, 1, 0, 2'd1, 4'd0); expect_beats(last_edge, 2, 2, "R10");
    idle(4);
    tick(1, 0, 0, 1, 2'd0, 4'd0); expect_beats(last_edge, 1, 2, "R10");
    idle(4);
    tick(0, 1, 1, 0, 2'd0, 4'd0);
    #1 chk(wr_strobe == 1, "R10", "write beats stop", int'(wr_strobe), 1);
    idle(4);

    // R5: write lane enables with zero lag
    tick(0, 1, 0, 0, 2'd2, 4'b0100);
    #1 chk(wr_strobe == 1 && wr_lane_en == 4'b1011, "R5", "write lanes beat 0", int'(wr_lane_en), 11);
    tick(0, 0, 0, 0, 2'd0, 4'b0011);
    #1 chk(wr_strobe == 1 && wr_lane_en == 4'b1100, "R5", "write lanes beat 1", int'(wr_lane_en), 12);
    tick(0, 0, 0, 0, 2'd0, 4'b1000);
    #1 chk(wr_strobe == 1 && wr_lane_en == 4'b0111, "R5", "write lanes beat 2", int'(wr_lane_en), 7);
    tick(0, 0, 0, 0, 2'd0, 4'b1111);
    #1 chk(wr_strobe == 1 && wr_lane_en == 4'b0000, "R5", "write lanes beat 3", int'(wr_lane_en), 0);
    tick(0, 0, 0, 0, 2'd0, 4'b0101);
    #1 chk(wr_strobe == 0 && wr_lane_en == 4'b0000, "R5", "write lanes after burst", int'(wr_lane_en), 0);
    idle(6);

    chk(exp_cyc.size() == 0, "R2", "outstanding expected beats", exp_cyc.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule